// File: doc/BRIEF.md
# Multi-level channel priority arbiter

This block chooses which of sixteen transfer channels may run next. Each channel raises a pending bit and carries a small level field that places it in one of four priority levels. A channel on a higher level always beats one on a lower level. Each level can be switched off on its own. Inside a level the winner is either the lowest-numbered pending channel or, when the round-robin bit of that level is set, the next pending channel after the one that level granted last.

The grant is a registered one-hot vector. It comes with the winner's channel number, a one-hot word showing which level is executing, and a busy flag. A grant is held until the transfer engine pulses `release_i`. New requests never displace the current owner. When a grant is released, a new decision is taken on the same edge, so back-to-back transfers lose no cycle. Each level also keeps a record of the last channel it granted, and this record is visible at the ports.

Top module: `chprio_arbiter`

## Requirements
- R1: While `rst` is high and after it falls, `grant_o`, `act_lvl_o`, `act_id_o` and `act_busy_o` are zero until the first grant, and every per-level last-granted field reads 15.
- R2: Channel c is pending when `pend_i[c]` is 1. Its level is the unsigned value of `ch_lvl_i[2c+1:2c]`.
- R3: A channel whose level has its `lvl_en_i` bit at 0 is never granted, even when it is the only pending channel.
- R4: Among enabled levels with a pending channel, the highest-numbered level wins.
- R5: When `rr_en_i[l]` is 0, level l grants its lowest-numbered pending channel, and its last-granted field does not change.
- R6: When `rr_en_i[l]` is 1, level l searches upward from one past its last-granted field and wraps from 15 to 0. The granted channel is written into that field.
- R7: A decision is taken at a rising edge where the arbiter is idle or `release_i` is 1. The outputs show the result after that edge.
- R8: While busy and `release_i` is 0, the grant, ID, level word and last-granted fields hold, even if higher-priority requests arrive.
- R9: At a decision edge with no eligible request, the arbiter goes idle (`act_busy_o` 0, `grant_o` 0).
- R10: When busy, `grant_o` has the single bit `act_id_o` set and `act_lvl_o` has the single bit of the winner's level set. When idle, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 16 | Pending request per channel, bit n for channel n |
| ch_lvl_i | input | 32 | Packed 2-bit level per channel, channel n at bits 2n+1:2n |
| lvl_en_i | input | 4 | Per-level enable |
| rr_en_i | input | 4 | Per-level round-robin select (0 = static) |
| release_i | input | 1 | Current transfer finished; allows a new decision |
| grant_o | output | 16 | One-hot grant |
| act_id_o | output | 4 | Granted channel number |
| act_lvl_o | output | 4 | One-hot executing level |
| act_busy_o | output | 1 | A grant is held |
| last_ch_o | output | 16 | Packed per-level last-granted channel, level l at bits 4l+3:4l |

## Verification
The assertions check the following on every cycle:
- the grant is one-hot and agrees with the ID and the level word;
- an idle arbiter drives nothing;
- a held grant and the last-granted fields stay frozen until release;
- a fresh grant always lands on a level that was enabled at the decision edge;
- a decision with nothing pending leaves the arbiter idle.

The choice of winner needs the bench's scenarios and its cycle model. This covers which level wins, the lowest-first order in static mode, and the wrap of the round-robin search from 15 to 0.

// File: rtl/chprio_pkg.sv
package chprio_pkg;
  parameter int unsigned CHPRIO_NUM_CH  = 16;
  parameter int unsigned CHPRIO_NUM_LVL = 4;

  function automatic int unsigned chprio_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/chprio_lvl_pick.sv
module chprio_lvl_pick #(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned CH_W = chprio_pkg::chprio_w(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  input  logic              rr_mode,
  input  logic [CH_W-1:0]   last,
  output logic              hit,
  output logic [CH_W-1:0]   pick
);
  logic        found;
  logic [31:0] idx;

  always_comb begin
    hit   = |req;
    pick  = '0;
    found = 1'b0;
    idx   = '0;
    if (rr_mode) begin
      for (int i = 1; i <= int'(NUM_CH); i++) begin
        idx = (32'(last) + 32'(i)) % 32'(NUM_CH);
        if (!found && req[idx[CH_W-1:0]]) begin
          pick  = idx[CH_W-1:0];
          found = 1'b1;
        end
      end
    end else begin
      for (int i = 0; i < int'(NUM_CH); i++) begin
        if (!found && req[i]) begin
          pick  = CH_W'(i);
          found = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chprio_lvl_sel.sv
module chprio_lvl_sel #(
  parameter int unsigned NUM_LVL = 4,
  localparam int unsigned LVL_W = chprio_pkg::chprio_w(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] hit,
  output logic               any,
  output logic [LVL_W-1:0]   lvl
);
  always_comb begin
    any = 1'b0;
    lvl = '0;
    for (int l = 0; l < int'(NUM_LVL); l++) begin
      if (hit[l]) begin
        any = 1'b1;
        lvl = LVL_W'(l);
      end
    end
  end
endmodule

// File: rtl/chprio_arbiter.sv
module chprio_arbiter #(
  parameter int unsigned NUM_CH  = chprio_pkg::CHPRIO_NUM_CH,
  parameter int unsigned NUM_LVL = chprio_pkg::CHPRIO_NUM_LVL,
  localparam int unsigned CH_W  = chprio_pkg::chprio_w(NUM_CH),
  localparam int unsigned LVL_W = chprio_pkg::chprio_w(NUM_LVL)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       pend_i,
  input  logic [NUM_CH*LVL_W-1:0] ch_lvl_i,
  input  logic [NUM_LVL-1:0]      lvl_en_i,
  input  logic [NUM_LVL-1:0]      rr_en_i,
  input  logic                    release_i,
  output logic [NUM_CH-1:0]       grant_o,
  output logic [CH_W-1:0]         act_id_o,
  output logic [NUM_LVL-1:0]      act_lvl_o,
  output logic                    act_busy_o,
  output logic [NUM_LVL*CH_W-1:0] last_ch_o
);
  logic [NUM_CH-1:0]  req_by_lvl [NUM_LVL];
  logic [NUM_LVL-1:0] lvl_hit;
  logic [CH_W-1:0]    lvl_pick   [NUM_LVL];
  logic [CH_W-1:0]    last_q     [NUM_LVL];
  logic               win_any;
  logic [LVL_W-1:0]   win_lvl;
  logic [CH_W-1:0]    win_ch;
  logic               decide;

  // Sort requests into levels and pick a candidate per level
  for (genvar l = 0; l < int'(NUM_LVL); l++) begin : g_lvl
    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
      assign req_by_lvl[l][c] = pend_i[c] & lvl_en_i[l] &
                                (ch_lvl_i[c*LVL_W +: LVL_W] == LVL_W'(l));
    end
    chprio_lvl_pick #(.NUM_CH(NUM_CH)) u_pick (
      .req     (req_by_lvl[l]),
      .rr_mode (rr_en_i[l]),
      .last    (last_q[l]),
      .hit     (lvl_hit[l]),
      .pick    (lvl_pick[l])
    );
    assign last_ch_o[l*CH_W +: CH_W] = last_q[l];
  end

  chprio_lvl_sel #(.NUM_LVL(NUM_LVL)) u_sel (
    .hit (lvl_hit),
    .any (win_any),
    .lvl (win_lvl)
  );

  assign win_ch = lvl_pick[win_lvl];
  assign decide = !act_busy_o || release_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_busy_o <= 1'b0;
      grant_o    <= '0;
      act_id_o   <= '0;
      act_lvl_o  <= '0;
      for (int l = 0; l < int'(NUM_LVL); l++) last_q[l] <= '1;
    end else if (decide) begin
      act_busy_o <= win_any;
      if (win_any) begin
        grant_o   <= NUM_CH'(1) << win_ch;
        act_id_o  <= win_ch;
        act_lvl_o <= NUM_LVL'(1) << win_lvl;
        if (rr_en_i[win_lvl]) last_q[win_lvl] <= win_ch;
      end else begin
        grant_o   <= '0;
        act_id_o  <= '0;
        act_lvl_o <= '0;
      end
    end
  end
endmodule

// File: rtl/chprio_arbiter_chk.sv
module chprio_arbiter_chk #(
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned NUM_LVL = 4,
  localparam int unsigned CH_W  = chprio_pkg::chprio_w(NUM_CH),
  localparam int unsigned LVL_W = chprio_pkg::chprio_w(NUM_LVL)
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_CH-1:0]       pend_i,
  input logic [NUM_CH*LVL_W-1:0] ch_lvl_i,
  input logic [NUM_LVL-1:0]      lvl_en_i,
  input logic [NUM_LVL-1:0]      rr_en_i,
  input logic                    release_i,
  input logic [NUM_CH-1:0]       grant_o,
  input logic [CH_W-1:0]         act_id_o,
  input logic [NUM_LVL-1:0]      act_lvl_o,
  input logic                    act_busy_o,
  input logic [NUM_LVL*CH_W-1:0] last_ch_o
);
  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  // R10
  grant_id_chk: assert property (@(posedge clk) disable iff (rst)
    act_busy_o |-> (grant_o == (NUM_CH'(1) << act_id_o)) && $onehot(act_lvl_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !act_busy_o |-> (grant_o == '0) && (act_lvl_o == '0));

  // R8
  hold_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (act_busy_o && !release_i) |=> $stable(grant_o) && $stable(act_lvl_o) && act_busy_o);

  // R8
  hold_last_chk: assert property (@(posedge clk) disable iff (rst)
    (act_busy_o && !release_i) |=> $stable(last_ch_o));

  // R3
  enabled_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_busy_o || release_i) |=> (!act_busy_o || ((act_lvl_o & $past(lvl_en_i)) != '0)));

  // R9
  go_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((!act_busy_o || release_i) && pend_i == '0) |=> !act_busy_o);
endmodule

bind chprio_arbiter chprio_arbiter_chk #(.NUM_CH(NUM_CH), .NUM_LVL(NUM_LVL)) u_chk (.*);

// File: tb/chprio_arbiter_tb.sv
`timescale 1ns/1ps
module chprio_arbiter_tb;
  localparam int NCH = 16;
  localparam int NLV = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   pend = '0;
  logic [31:0]   chlvl = '0;
  logic [3:0]    lven = '0;
  logic [3:0]    rren = '0;
  logic          rel = 1'b0;
  logic [15:0]   grant;
  logic [3:0]    act_id;
  logic [3:0]    act_lvl;
  logic          busy;
  logic [15:0]   last_ch;

  int checks = 0;
  int failures = 0;

  // reference state
  bit m_busy;
  int m_ch, m_lvl;
  int m_last[NLV];

  always #2.5 clk = ~clk;

  chprio_arbiter u_dut (
    .clk(clk), .rst(rst), .pend_i(pend), .ch_lvl_i(chlvl), .lvl_en_i(lven),
    .rr_en_i(rren), .release_i(rel), .grant_o(grant), .act_id_o(act_id),
    .act_lvl_o(act_lvl), .act_busy_o(busy), .last_ch_o(last_ch)
  );

  function automatic int lvl_of(int c);
    return int'(chlvl[c*2 +: 2]);
  endfunction

  task automatic model_step();
    int best_l;
    int pick;
    if (m_busy && !rel) return;
    best_l = -1;
    for (int l = NLV - 1; l >= 0 && best_l < 0; l--)
      if (lven[l])
        for (int c = 0; c < NCH; c++)
          if (pend[c] && lvl_of(c) == l) best_l = l;
    if (best_l < 0) begin
      m_busy = 0; m_ch = 0; m_lvl = 0;
      return;
    end
    pick = -1;
    if (rren[best_l]) begin
      for (int k = 1; k <= NCH && pick < 0; k++) begin
        int c = (m_last[best_l] + k) % NCH;
        if (pend[c] && lvl_of(c) == best_l) pick = c;
      end
      m_last[best_l] = pick;
    end else begin
      for (int c = 0; c < NCH && pick < 0; c++)
        if (pend[c] && lvl_of(c) == best_l) pick = c;
    end
    m_busy = 1; m_ch = pick; m_lvl = best_l;
  endtask

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check(string tag);
    logic [15:0] e_last;
    for (int l = 0; l < NLV; l++) e_last[l*4 +: 4] = 4'(m_last[l]);
    cmp(tag, "busy", int'(busy), int'(m_busy));
    cmp(tag, "grant", int'(grant), m_busy ? (1 << m_ch) : 0);
    cmp(tag, "id", int'(act_id), m_busy ? m_ch : 0);
    cmp(tag, "level", int'(act_lvl), m_busy ? (1 << m_lvl) : 0);
    cmp(tag, "last", int'(last_ch), int'(e_last));
  endtask

  task automatic step(string tag);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_busy = 0; m_ch = 0; m_lvl = 0;
    for (int l = 0; l < NLV; l++) m_last[l] = 15;
    repeat (3) @(negedge clk);
    check("R1");
    rst = 1'b0;
    @(negedge clk);
    check("R1");

    // level mapping: ch9 on level 1, ch5 on level 2, rest level 0
    lven = 4'b1111; rren = 4'b0000;
    chlvl[9*2 +: 2] = 2'd1;
    chlvl[5*2 +: 2] = 2'd2;
    pend = 16'h0208;                 // ch3, ch9
    step("R4");                      // ch9
    pend = pend | 16'h0020;          // ch5 arrives, no release
    step("R8");
    step("R8");
    rel = 1'b1;
    step("R4");                      // ch5 on level 2
    lven = 4'b1011;                  // level 2 off
    step("R3");                      // ch9
    pend = 16'h0020;                 // only a disabled-level channel
    step("R3");                      // idle
    pend = 16'h0088;                 // ch3, ch7 on level 0
    step("R5");
    step("R5");
    rren = 4'b0001;
    step("R6");                      // ch3
    step("R6");                      // ch7
    step("R6");                      // wraps to ch3
    chlvl[3*2 +: 2] = 2'd3; lven = 4'b1111;
    step("R2");                      // ch3 on level 3
    pend = 16'h0000;
    step("R9");
    rel = 1'b0; pend = 16'h1000;
    step("R7");                      // idle arbiter takes ch12
    pend = 16'h0000;
    step("R8");

    for (int n = 0; n < 3000; n++) begin
      pend  = 16'($urandom);
      if (n % 50 == 0) begin
        chlvl = $urandom;
        lven  = 4'($urandom);
        rren  = 4'($urandom);
      end
      rel = ($urandom % 3) == 0;
      step("R10");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule